// File: doc/BRIEF.md
# 33-to-16 Bit Transmit Gearbox

This block sits between a line encoder that produces 66-bit blocks, delivered as two 33-bit halves, and a 16:1 serializer that takes a 16-bit word on each cycle of its word clock. The two widths do not divide each other. The block therefore keeps a residue of leftover bits, appends each new input word after it, and peels 16-bit words off the front. The whole block runs on the single output-word clock. Sixteen input words carry 528 bits, which is exactly 33 output words, so under full load the pattern repeats every 33 cycles.

The upstream side presents a word with a valid strobe, and a word counts as taken on any cycle where both valid and ready are high. The downstream side receives a 16-bit word with an output-valid flag on every cycle where at least 16 bits are held. Bits travel least-significant first. Bit 0 of an input word goes onto the line right after the last bit already held, and bit 0 of each output word is the first to be sent.

Top module: `txgear_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, `out_valid` is low and `in_ready` is high, because the residue is empty.
- R2: `in_ready` is high exactly when the held bit count, less the 16 bits leaving on that cycle (if any), is below 16. The held count therefore never exceeds 48.
- R3: `out_valid` is high exactly on cycles where 16 or more bits are held. On each such cycle one word leaves and the held count drops by 16.
- R4: The concatenation of all output words, each sent bit 0 first, equals the concatenation of all accepted input words, each taken bit 0 first, with no bit lost, repeated or reordered. For example, a single word 0x1_2345_6789 gives the words 0x6789 and then 0x2345, and one bit stays held.
- R5: With `in_valid` held high from reset, `out_valid` is high on every cycle from the second cycle onward, with no bubble.
- R6: With `in_valid` held high from reset, every window of 33 consecutive cycles starting one cycle after the first acceptance accepts exactly 16 input words.
- R7: When input stops, the block keeps emitting words until fewer than 16 bits remain, then holds `out_valid` low. The remaining bits stay held and lead the next output word.
- R8: On cycles where `in_valid` is low, `in_data` has no effect on any later output word.
- R9: A reset in mid-stream discards all held bits. The first output word after it starts with bit 0 of the first word accepted after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 33 | Half of a 66-bit encoded block, bit 0 sent first |
| in_valid | input | 1 | `in_data` holds a word to transfer |
| in_ready | output | 1 | Block takes `in_data` at this edge if `in_valid` is high |
| out_data | output | 16 | Word for the serializer, bit 0 sent first |
| out_valid | output | 1 | `out_data` carries a word on this cycle |

## Verification
The assertions assume that `in_valid` and `in_data` are steady for a whole cycle and that `rst` is high from time zero until the first edges have passed. They also assume that upstream only counts a word as taken on a cycle where it sees `in_ready` high. The bench changes every input at the falling edge and reads outputs one step later, so each value is settled well before the next rising edge. It also keeps a reference fill count and bit queue of its own, so a word counts as taken only under the same valid-and-ready rule.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    // Default widths: half of a 66-bit block in, one serializer word out.
    parameter int GBX_IN_W  = 33;
    parameter int GBX_OUT_W = 16;

    // Action chosen for the current cycle.
    typedef enum logic [1:0] {
        ACT_IDLE = 2'b00,
        ACT_TAKE = 2'b01,
        ACT_EMIT = 2'b10,
        ACT_BOTH = 2'b11
    } gbx_act_t;

    function automatic logic act_emits(input gbx_act_t a);
        return (a == ACT_EMIT) || (a == ACT_BOTH);
    endfunction

    function automatic logic act_takes(input gbx_act_t a);
        return (a == ACT_TAKE) || (a == ACT_BOTH);
    endfunction

    function automatic gbx_act_t act_of(input logic emit, input logic take);
        return gbx_act_t'({emit, take});
    endfunction

endpackage

// File: rtl/gbx_level.sv
// Fill-level control: tracks how many bits the residue holds and decides
// each cycle whether a word leaves and whether a new word enters.
module gbx_level
    import gbx_pkg::*;
#(
    parameter int IN_W  = GBX_IN_W,
    parameter int OUT_W = GBX_OUT_W,
    localparam int HOLD_W = IN_W + OUT_W - 1,
    localparam int CNT_W  = $clog2(HOLD_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] base,
    output gbx_act_t         act,
    output logic             in_ready,
    output logic             out_valid
);

    // Room for a new word once one output word has left.
    localparam int ROOM_LIM = 2 * OUT_W;

    logic             take;
    logic [CNT_W-1:0] fill_nxt;

    always_comb begin
        out_valid = (fill >= CNT_W'(OUT_W));
        in_ready  = (fill <  CNT_W'(ROOM_LIM));
        take      = in_valid && in_ready;
        act       = act_of(out_valid, take);
        base      = out_valid ? (fill - CNT_W'(OUT_W)) : fill;
        fill_nxt  = take ? (base + CNT_W'(IN_W)) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else begin
            fill <= fill_nxt;
        end
    end

endmodule

// File: rtl/gbx_merge.sv
// Residue datapath: drops the leaving word off the bottom and lays a new
// input word directly above the bits that remain.
module gbx_merge
    import gbx_pkg::*;
#(
    parameter int IN_W  = GBX_IN_W,
    parameter int OUT_W = GBX_OUT_W,
    localparam int HOLD_W = IN_W + OUT_W - 1,
    localparam int CNT_W  = $clog2(HOLD_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  gbx_act_t         act,
    input  logic [CNT_W-1:0] base,
    input  logic [IN_W-1:0]  in_data,
    output logic [OUT_W-1:0] out_data
);

    logic [HOLD_W-1:0] hold;
    logic [HOLD_W-1:0] shifted;
    logic [HOLD_W-1:0] placed;
    logic [HOLD_W-1:0] hold_nxt;
    logic              emit;
    logic              take;

    always_comb begin
        emit    = act_emits(act);
        take    = act_takes(act);
        shifted = emit ? (hold >> OUT_W) : hold;
        placed  = HOLD_W'(in_data) << base;
    end

    // Per-bit select: below the fill point keep old bits, above it take the
    // new word or clear, so bits past the fill point are always zero.
    for (genvar i = 0; i < HOLD_W; i++) begin : g_bit
        logic keep_lo;
        assign keep_lo     = (CNT_W'(i) < base);
        assign hold_nxt[i] = keep_lo ? shifted[i] : (take & placed[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else begin
            hold <= hold_nxt;
        end
    end

    assign out_data = hold[OUT_W-1:0];

endmodule

// File: rtl/txgear_top.sv
module txgear_top
    import gbx_pkg::*;
#(
    parameter int IN_W  = GBX_IN_W,
    parameter int OUT_W = GBX_OUT_W,
    localparam int HOLD_W = IN_W + OUT_W - 1,
    localparam int CNT_W  = $clog2(HOLD_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid
);

    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] base;
    gbx_act_t         act;

    gbx_level #(.IN_W(IN_W), .OUT_W(OUT_W)) u_level (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .fill      (fill),
        .base      (base),
        .act       (act),
        .in_ready  (in_ready),
        .out_valid (out_valid)
    );

    gbx_merge #(.IN_W(IN_W), .OUT_W(OUT_W)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .base     (base),
        .in_data  (in_data),
        .out_data (out_data)
    );

endmodule

// File: rtl/txgear_check.sv
module txgear_check #(
    parameter int IN_W  = 33,
    parameter int OUT_W = 16,
    localparam int HOLD_W = IN_W + OUT_W - 1,
    localparam int CNT_W  = $clog2(HOLD_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [CNT_W-1:0] fill
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= HOLD_W);

    assert_take_step_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=>
            int'(fill) == int'($past(fill)) - ($past(out_valid) ? OUT_W : 0) + IN_W);

    assert_low_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (int'(fill) < OUT_W) |-> (!out_valid && in_ready));

    assert_drain_R7: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && out_valid) |=> int'(fill) == int'($past(fill)) - OUT_W);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> $stable(fill));

endmodule

bind txgear_top txgear_check #(.IN_W(IN_W), .OUT_W(OUT_W)) u_check (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .fill      (fill)
);

// File: tb/txgear_top_bench.sv
`timescale 1ns/100ps
module txgear_top_bench;

    localparam int IW = 33;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [OW-1:0] out_data;
    logic          out_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int   mfill = 0;       // reference held bit count
    bit   bitq[$];         // reference bitstream
    int   n_out = 0;       // words seen since last reset
    logic last_word_ok;
    logic [OW-1:0] last_word;

    always #2.5 clk = ~clk;

    txgear_top u_txgear_top (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string req, input longint act_v, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // One cycle: drive at falling edge, sample mid-cycle, compare with model.
    task automatic step(input bit v, input logic [IW-1:0] d, output bit took);
        logic [OW-1:0] expw;
        bit ev;
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        #1;
        ev = (mfill >= OW);
        check(in_ready == ((mfill - (ev ? OW : 0)) < OW), "R2 ready", in_ready, !in_ready);
        check(out_valid == ev, "R3 out_valid", out_valid, ev);
        took = v && in_ready;
        if (out_valid && bitq.size() >= OW) begin
            for (int i = 0; i < OW; i++) expw[i] = bitq.pop_front();
            check(out_data == expw, "R4 bitstream", out_data, expw);
            last_word = out_data;
            n_out++;
        end
        if (took)
            for (int i = 0; i < IW; i++) bitq.push_back(d[i]);
        mfill = mfill - (ev ? OW : 0) + (took ? IW : 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(!out_valid && in_ready, "R1 during reset", {out_valid, in_ready}, 2'b01);
        @(negedge clk);
        rst = 1'b0;
        mfill = 0;
        bitq.delete();
        n_out = 0;
        #1;
        check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);
    endtask

    function automatic logic [IW-1:0] rnd_word();
        return IW'({$urandom(), $urandom()});
    endfunction

    task automatic t_first_word();
        bit tk;
        do_reset();
        step(1, 33'h1_2345_6789, tk);
        step(0, '0, tk);
        check(last_word == 16'h6789, "R4 first word low", last_word, 16'h6789);
        step(0, '0, tk);
        check(last_word == 16'h2345, "R4 first word high", last_word, 16'h2345);
        step(0, '0, tk);
        check(!out_valid && n_out == 2, "R7 one bit left held", n_out, 2);
        // next word: held bit 1 then bits 0..14 of 0x0_0000_7FFE
        step(1, 33'h0_0000_7FFE, tk);
        step(0, '0, tk);
        check(last_word == 16'hFFFD, "R4 residue joins next", last_word, 16'hFFFD);
    endtask

    task automatic t_saturated();
        bit tk;
        int acc;
        bit bubble;
        do_reset();
        step(1, rnd_word(), tk);
        for (int w = 0; w < 4; w++) begin
            acc = 0;
            bubble = 0;
            for (int c = 0; c < 33; c++) begin
                step(1, rnd_word(), tk);
                if (tk) acc++;
                if (!out_valid) bubble = 1;
            end
            check(acc == 16, "R6 accepts per 33 cycles", acc, 16);
            check(!bubble, "R5 no output bubble", bubble, 0);
        end
    endtask

    task automatic t_starve_garbage();
        bit tk;
        int taken = 0;
        int start_out;
        do_reset();
        for (int c = 0; c < 400; c++) begin
            if ($urandom_range(0, 2) == 0) begin
                step(1, rnd_word(), tk);
                if (tk) taken++;
            end else begin
                step(0, rnd_word(), tk);   // garbage while not valid
            end
        end
        check(errors == 0, "R8 garbage ignored", errors, 0);
        start_out = n_out;
        for (int c = 0; c < 8; c++) step(0, rnd_word(), tk);
        check(n_out == (taken * IW) / OW, "R7 drain count", n_out, (taken * IW) / OW);
        check(!out_valid, "R7 stops below 16", out_valid, 0);
        check(bitq.size() == (taken * IW) % OW, "R7 residue kept", bitq.size(), (taken * IW) % OW);
        if (start_out > n_out) check(0, "R7 count", start_out, n_out);
    endtask

    task automatic t_mid_reset();
        bit tk;
        do_reset();
        for (int c = 0; c < 7; c++) step(1, rnd_word(), tk);
        do_reset();
        step(1, 33'h0_BEEF_CAFE, tk);
        step(0, '0, tk);
        check(last_word == 16'hCAFE && n_out == 1, "R9 restart aligned", last_word, 16'hCAFE);
        step(0, '0, tk);
        check(last_word == 16'hBEEF, "R9 second word", last_word, 16'hBEEF);
    endtask

    initial begin
        t_first_word();
        t_saturated();
        t_starve_garbage();
        t_mid_reset();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule